// File: doc/BRIEF.md
# Multichannel DAC Serial Command Slave

This block is the digital serial front end of a bank of 32 channel registers, each 14 bits wide, plus one offset register. A host drives a frame strobe (active low), a serial clock and a data line. The block decodes a 10-bit control header, then takes 14 data bits for a register write. For the readback modes it queues the addressed register, and the next frame shifts that value out on a data output that is enabled only while the frame runs.

All three serial inputs pass through synchronisers into the system clock, and edges are found from the synchronised samples. The serial clock must therefore run at no more than one quarter of the system clock. Each frame opens on a falling edge of the frame strobe. A bit counter then fixes its length by mode: 24 bits for a write, 10 bits for a readback or acquisition header, 14 bits for a readback frame. Analog acquisition is modelled as a busy flag that stays high for a set number of system clocks.

The output pair `dout`/`dout_oe` is meant for a tri-state pad driver outside the block. The header is sent MSB first: mode[1:0], calibrate, test, offset-select, then address A4..A0. The 14 data bits follow, also MSB first.

Top module: `dac_serial_slave`

## Requirements
- R1: A mode-00 frame carries 24 bits, MSB first: the header in bits 23..14 and the data in bits 13..0. It writes the data into the channel given by header bits 4..0, where bit 4 is the address MSB.
- R2: With header bit 5 (offset-select) high, the offset register is the target of a write or readback, and address bits 4..0 are ignored.
- R3: A mode-10 header is 10 bits long. The frame opened by the next strobe falling edge shifts out the addressed register as 14 bits, MSB first. Each bit is launched on an SCLK rising edge.
- R4: `dout_oe` goes high on the first SCLK rising edge of a readback frame and low after the 14th SCLK falling edge. It is low at all other times.
- R5: A mode-00 write with header bit 7 (calibrate) high loads all 32 channel registers at once: with all ones if data bit 13 is 1, with all zeros if it is 0. The offset register is left unchanged.
- R6: A frame whose header bit 6 (test) is high has no effect on any register, readback or acquisition.
- R7: Strobe falling edges that arrive before the frame's bit count is reached do not restart or shorten the frame.
- R8: SCLK edges after the frame's last bit and before the next strobe falling edge are ignored.
- R9: Modes 01 and 11 raise `acq_busy` for ACQ_CYCLES system clocks after the header. `acq_all` follows the calibrate bit while busy. Mode 11 queues no readback, so the next frame is decoded as a new command.
- R10: Mode 01 queues a readback just as mode 10 does. A readback returns the register value captured when its header ended, even when the frame starts while `acq_busy` is high. DIN is ignored throughout a readback frame.
- R11: After reset all registers read zero, `dout_oe` and `acq_busy` are low, and no readback is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial readback data |
| dout_oe | output | 1 | Output enable for the DOUT pad driver |
| acq_busy | output | 1 | Acquisition in progress |
| acq_all | output | 1 | Current acquisition covers all channels |

## Verification
The embedded assertions check on every cycle that the bit counter never passes the write length, and that `dout_oe` is high only inside a readback frame. They also check that a strobe edge inside a receiving frame leaves the count alone, that nothing is shifted while no frame is open, that a plain or calibrated write lands in the register bank with the offset register untouched, and that every acquisition start raises the busy flag. Only the bench scenarios can show the end-to-end results: values round-tripping through the serial format on every channel, a readback taken while busy returning the captured value, mode 11 leaving no readback pending, and test-bit frames leaving the readback value unchanged.

// File: rtl/dss_pkg.sv
package dss_pkg;

  localparam int ADDR_W = 5;
  localparam int HDR_W  = 5 + ADDR_W;

  typedef enum logic [1:0] {
    MD_WRITE  = 2'b00,
    MD_ACQ_RB = 2'b01,
    MD_RB     = 2'b10,
    MD_ACQ    = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic              cal;
    logic              test;
    logic              offs;
    logic [ADDR_W-1:0] addr;
  } hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_RB   = 2'd2
  } fstate_e;

  function automatic logic mode_reads_back(mode_e m);
    return (m == MD_ACQ_RB) || (m == MD_RB);
  endfunction

  function automatic logic mode_acquires(mode_e m);
    return (m == MD_ACQ_RB) || (m == MD_ACQ);
  endfunction

  function automatic int frame_bits(mode_e m, int dw);
    return (m == MD_WRITE) ? (HDR_W + dw) : HDR_W;
  endfunction

endpackage

// File: rtl/dss_edge_sync.sv
module dss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic sclk,
  input  logic din,
  output logic sync_fall,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] s_now;
  logic [1:0]      ctl_prev;

  assign raw = {din, sclk, sync_n};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign s_now[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_prev <= 2'b11;
    else        ctl_prev <= s_now[1:0];
  end

  assign sync_fall = ctl_prev[0] & ~s_now[0];
  assign sclk_fall = ctl_prev[1] & ~s_now[1];
  assign sclk_rise = ~ctl_prev[1] & s_now[1];
  assign din_s     = s_now[2];

endmodule

// File: rtl/dss_regbank.sv
module dss_regbank #(
  parameter int NCH   = 32,
  parameter int DW    = 14,
  parameter int IDX_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             cal_load,
  input  logic             cal_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);

  localparam logic [IDX_W-1:0] OFFS_IDX = IDX_W'(NCH);

  logic [DW-1:0] regs [NCH+1];

  for (genvar g = 0; g <= NCH; g++) begin : g_reg
    if (g < NCH) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              regs[g] <= '0;
        else if (cal_load)                       regs[g] <= {DW{cal_val}};
        else if (wr_en && wr_idx == IDX_W'(g))   regs[g] <= wr_data;
      end
    end else begin : g_offs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              regs[g] <= '0;
        else if (wr_en && wr_idx == OFFS_IDX)    regs[g] <= wr_data;
      end
    end
  end

  assign rd_data = (rd_idx <= OFFS_IDX) ? regs[rd_idx] : '0;

  // R1: a plain write shows up in the addressed register next cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cal_load && wr_idx <= OFFS_IDX) |=> regs[$past(wr_idx)] == $past(wr_data));

  // R5: calibrated load fills the first and last channel with the pattern
  p_cal_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load |=> (regs[0] == {DW{$past(cal_val)}}) && (regs[NCH-1] == {DW{$past(cal_val)}}));

  // R5: offset register untouched by a calibrated load
  p_cal_keeps_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_load && !wr_en) |=> $stable(regs[NCH]));

endmodule

// File: rtl/dss_acq_timer.sv
module dss_acq_timer #(
  parameter int ACQ_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_all,
  output logic busy,
  output logic all_ch
);

  localparam int CW = $clog2(ACQ_CYCLES + 1);

  logic [CW-1:0] remain;
  logic          all_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      all_q  <= 1'b0;
    end else if (start) begin
      remain <= CW'(ACQ_CYCLES);
      all_q  <= start_all;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy   = (remain != '0);
  assign all_ch = busy & all_q;

  // R9: every acquisition start raises the busy flag
  p_busy_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R9: the all-channel flag never shows outside an acquisition
  p_all_within_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_ch |-> busy);

endmodule

// File: rtl/dss_frame.sv
module dss_frame
  import dss_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int DW    = 14,
  parameter int IDX_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_fall,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             din_s,
  input  logic [DW-1:0]    rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             cal_load,
  output logic             cal_val,
  output logic             acq_start,
  output logic             acq_cal,
  output logic             dout,
  output logic             dout_oe
);

  localparam int WR_LEN = HDR_W + DW;
  localparam int CNT_W  = $clog2(WR_LEN + 1);
  localparam int RC_W   = $clog2(DW + 1);

  fstate_e           st;
  logic [WR_LEN-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              rb_pend;
  logic [DW-1:0]     rb_snap;
  logic [DW-1:0]     out_sr;
  logic [RC_W-1:0]   rcnt;

  // named internal events
  logic [WR_LEN-1:0] sr_n;
  logic [CNT_W-1:0]  cnt_n;
  hdr_t              h_early;
  hdr_t              h_late;
  logic              rx_bit;
  logic              short_end;
  logic              wr_end;
  logic              rb_queue;
  logic              rb_launch;
  logic              rb_sample;
  logic              rb_end;

  function automatic logic [IDX_W-1:0] target(hdr_t h);
    return h.offs ? IDX_W'(NCH) : IDX_W'(h.addr);
  endfunction

  assign sr_n    = {sr[WR_LEN-2:0], din_s};
  assign cnt_n   = cnt + 1'b1;
  assign h_early = hdr_t'(sr_n[HDR_W-1:0]);
  assign h_late  = hdr_t'(sr_n[WR_LEN-1:DW]);

  assign rx_bit    = (st == ST_RX) && sclk_fall;
  assign short_end = rx_bit && (cnt_n == CNT_W'(HDR_W)) && (h_early.mode != MD_WRITE);
  assign wr_end    = rx_bit && (cnt_n == CNT_W'(WR_LEN)) && (h_late.mode == MD_WRITE);
  assign rb_queue  = short_end && !h_early.test && mode_reads_back(h_early.mode);

  assign rb_launch = (st == ST_RB) && sclk_rise && (rcnt < RC_W'(DW));
  assign rb_sample = (st == ST_RB) && sclk_fall && (rcnt != '0);
  assign rb_end    = rb_sample && (cnt_n == CNT_W'(DW));

  assign wr_en     = wr_end && !h_late.test && !h_late.cal;
  assign cal_load  = wr_end && !h_late.test && h_late.cal;
  assign cal_val   = sr_n[DW-1];
  assign wr_idx    = target(h_late);
  assign wr_data   = sr_n[DW-1:0];
  assign rd_idx    = target(h_early);
  assign acq_start = short_end && !h_early.test && mode_acquires(h_early.mode);
  assign acq_cal   = h_early.cal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sr      <= '0;
      cnt     <= '0;
      rb_pend <= 1'b0;
      rb_snap <= '0;
      out_sr  <= '0;
      rcnt    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (sync_fall) begin
            cnt <= '0;
            if (rb_pend) begin
              st      <= ST_RB;
              rb_pend <= 1'b0;
              out_sr  <= rb_snap;
              rcnt    <= '0;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (rx_bit) begin
            sr  <= sr_n;
            cnt <= cnt_n;
            if (short_end || (cnt_n == CNT_W'(WR_LEN))) st <= ST_IDLE;
            if (rb_queue) begin
              rb_pend <= 1'b1;
              rb_snap <= rd_data;
            end
          end
        end
        ST_RB: begin
          if (rb_launch) begin
            dout_oe <= 1'b1;
            dout    <= out_sr[DW-1];
            out_sr  <= {out_sr[DW-2:0], 1'b0};
            rcnt    <= rcnt + 1'b1;
          end
          if (rb_sample) begin
            cnt <= cnt_n;
            if (rb_end) begin
              st      <= ST_IDLE;
              dout_oe <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: the bit counter never runs past the longest frame
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WR_LEN));

  // R4: the output driver is enabled only inside a readback frame
  p_oe_in_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (st == ST_RB));

  // R7: a strobe edge inside a receiving frame keeps the count
  p_sync_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && sync_fall && !sclk_fall) |=> (st == ST_RX) && (cnt == $past(cnt)));

  // R8: with no frame open, serial clock edges shift nothing
  p_sclk_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !sync_fall) |=> $stable(sr));

  // R10: a queued readback holds its captured value until its frame opens
  p_snap_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_pend && !rb_queue) |=> $stable(rb_snap));

endmodule

// File: rtl/dac_serial_slave.sv
module dac_serial_slave #(
  parameter int NCH        = 32,
  parameter int DW         = 14,
  parameter int SYNC_STG   = 2,
  parameter int ACQ_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_oe,
  output logic acq_busy,
  output logic acq_all
);

  localparam int IDX_W = $clog2(NCH + 1);

  logic             sync_fall, sclk_rise, sclk_fall, din_s;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [DW-1:0]    rd_data, wr_data;
  logic             wr_en, cal_load, cal_val, acq_start, acq_cal;

  dss_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .sclk      (sclk),
    .din       (din),
    .sync_fall (sync_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din_s     (din_s)
  );

  dss_frame #(.NCH(NCH), .DW(DW), .IDX_W(IDX_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_fall (sync_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din_s     (din_s),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .cal_load  (cal_load),
    .cal_val   (cal_val),
    .acq_start (acq_start),
    .acq_cal   (acq_cal),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  dss_regbank #(.NCH(NCH), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cal_load (cal_load),
    .cal_val  (cal_val),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  dss_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acq_start),
    .start_all (acq_cal),
    .busy      (acq_busy),
    .all_ch    (acq_all)
  );

  // R6/R9: no register change and no acquisition start in the same cycle
  p_write_acq_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en || cal_load) && acq_start));

endmodule

// File: tb/dac_serial_slave_test.sv
module dac_serial_slave_test;

  localparam int H   = 6;   // system clocks per SCLK half period
  localparam int ACQ = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic dout, dout_oe, acq_busy, acq_all;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dac_serial_slave #(.ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .acq_busy(acq_busy), .acq_all(acq_all)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] hdr(input int m, input bit cal, input bit tst,
                                      input bit offs, input int addr);
    return {m[1:0], cal, tst, offs, addr[4:0]};
  endfunction

  function automatic logic [13:0] pat(input int ch);
    return 14'((ch * 1237 + 291) & 16'h3FFF);
  endfunction

  task automatic send(input logic [23:0] w, input int n, input int extra, input int glitch_at);
    sclk = 1'b1; sync_n = 1'b0; wclk(H);
    for (int i = n - 1; i >= 0; i--) begin
      if ((n - 1 - i) == glitch_at) begin
        sync_n = 1'b1; wclk(H); sync_n = 1'b0; wclk(H);
      end
      din = w[i]; sclk = 1'b0; wclk(H); sclk = 1'b1; wclk(H);
    end
    for (int e = 0; e < extra; e++) begin
      din = 1'b1; sclk = 1'b0; wclk(H); sclk = 1'b1; wclk(H);
    end
    wclk(H); sync_n = 1'b1; wclk(H);
  endtask

  task automatic write_reg(input int ch, input logic [13:0] v, input bit offs,
                           input bit cal, input bit tst);
    send({hdr(0, cal, tst, offs, ch), v}, 24, 0, -1);
  endtask

  task automatic read_frame(output logic [13:0] v, output int oe_hi);
    oe_hi = 0;
    sclk = 1'b0; wclk(H);
    sync_n = 1'b0; wclk(H);
    for (int i = 13; i >= 0; i--) begin
      din = i[0];
      sclk = 1'b1; wclk(H);
      v[i] = dout;
      if (dout_oe) oe_hi++;
      sclk = 1'b0; wclk(H);
    end
    wclk(H); sync_n = 1'b1; wclk(H);
    sclk = 1'b1; wclk(H);
  endtask

  task automatic read_reg(input int ch, input bit offs, input string req, input int exp);
    logic [13:0] v;
    int oh;
    send({14'd0, hdr(2, 1'b0, 1'b0, offs, ch)}, 10, 0, -1);
    read_frame(v, oh);
    chk(req, "readback value", int'(v), exp);
    chk("R4", "dout_oe cycles high", oh, 14);
    chk("R4", "dout_oe after frame", int'(dout_oe), 0);
  endtask

  initial begin
    logic [13:0] v;
    int oh;
    rst_n = 1'b0; wclk(5); rst_n = 1'b1; wclk(5);

    // R11: reset state
    chk("R11", "dout_oe at reset", int'(dout_oe), 0);
    chk("R11", "acq_busy at reset", int'(acq_busy), 0);
    read_reg(5, 1'b0, "R11", 0);
    read_reg(0, 1'b1, "R11", 0);

    // R1, R3: sweep every channel
    for (int ch = 0; ch < 32; ch++) write_reg(ch, pat(ch), 1'b0, 1'b0, 1'b0);
    for (int ch = 0; ch < 32; ch++) read_reg(ch, 1'b0, "R1", int'(pat(ch)));
    // R10: DIN toggled during previous readbacks changed nothing
    read_reg(17, 1'b0, "R10", int'(pat(17)));

    // R2: offset register, address field ignored
    write_reg(7, 14'h1234, 1'b1, 1'b0, 1'b0);
    read_reg(31, 1'b1, "R2", 16'h1234);
    read_reg(7, 1'b0, "R2", int'(pat(7)));

    // R6: test bit blocks writes and readback queueing
    write_reg(3, 14'h0AAA, 1'b0, 1'b0, 1'b1);
    write_reg(3, 14'h3FFF, 1'b0, 1'b1, 1'b1);
    read_reg(3, 1'b0, "R6", int'(pat(3)));
    read_reg(20, 1'b0, "R6", int'(pat(20)));
    send({14'd0, hdr(1, 1'b0, 1'b1, 1'b0, 3)}, 10, 0, -1);
    chk("R6", "no acquisition on test frame", int'(acq_busy), 0);
    write_reg(3, 14'h0BCD, 1'b0, 1'b0, 1'b0);
    read_reg(3, 1'b0, "R6", 16'h0BCD);

    // R7: strobe pulse mid-frame is ignored
    send({hdr(0, 1'b0, 1'b0, 1'b0, 9), 14'h2222}, 24, 0, 12);
    read_reg(9, 1'b0, "R7", 16'h2222);

    // R8: extra clocks after a completed write are ignored
    send({hdr(0, 1'b0, 1'b0, 1'b0, 10), 14'h0155}, 24, 8, -1);
    read_reg(10, 1'b0, "R8", 16'h0155);
    read_reg(11, 1'b0, "R8", int'(pat(11)));

    // R9, R10: acquire plus readback, readback taken while busy
    send({14'd0, hdr(1, 1'b0, 1'b0, 1'b0, 4)}, 10, 0, -1);
    chk("R9", "busy after mode 01 header", int'(acq_busy), 1);
    chk("R9", "acq_all without cal", int'(acq_all), 0);
    read_frame(v, oh);
    chk("R10", "readback while busy", int'(v), int'(pat(4)));
    chk("R4", "dout_oe cycles high", oh, 14);
    wclk(ACQ + 10);
    chk("R9", "busy cleared", int'(acq_busy), 0);

    // R9: acquire only with cal, no readback queued
    send({14'd0, hdr(3, 1'b1, 1'b0, 1'b0, 4)}, 10, 0, -1);
    chk("R9", "busy after mode 11 header", int'(acq_busy), 1);
    chk("R9", "acq_all with cal", int'(acq_all), 1);
    write_reg(4, 14'h0777, 1'b0, 1'b0, 1'b0);
    chk("R9", "busy expired", int'(acq_busy), 0);
    chk("R9", "acq_all expired", int'(acq_all), 0);
    read_reg(4, 1'b0, "R9", 16'h0777);

    // R5: calibrated loads
    write_reg(0, 14'h2000, 1'b0, 1'b1, 1'b0);
    read_reg(0, 1'b0, "R5", 16'h3FFF);
    read_reg(31, 1'b0, "R5", 16'h3FFF);
    read_reg(16, 1'b0, "R5", 16'h3FFF);
    read_reg(0, 1'b1, "R5", 16'h1234);
    write_reg(5, 14'h1FFF, 1'b0, 1'b1, 1'b0);
    read_reg(17, 1'b0, "R5", 0);
    read_reg(2, 1'b0, "R5", 0);
    read_reg(0, 1'b1, "R5", 16'h1234);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule